// File: doc/BRIEF.md
# Transceiver Status Register Unit

This block is the status view that a host controller reads from a radio transceiver controller. It collects single-cycle event pulses from the PLL, calibration engines, non-volatile memory (EE) controller and ADC into sticky flags. It also reports a live command-ready level and a busy indication. Busy is formed from several activity sources. Some of these are plain level inputs. Others are spans opened and closed by start and done pulses, such as packet reception from chip-ID detection to the end of processing, and buffered transmission from the command to the actual send.

The host reads through an address and read-strobe port. The read data is combinational and reflects the state in the cycle of the strobe. A strobed read of the event register clears its sticky flags at the following clock edge, so the host sees each event once.

Top module: `radio_status_unit`

## Requirements
- R1: After synchronous reset all sticky flags and both transaction spans are clear. An event-register read then returns only the command-ready bit, and a busy-register read returns only the OR of the level activity inputs.
- R2: A one-cycle pulse on an event input sets its flag, and the flag stays set until a clearing read. The event register at address 0x01 lays out the flags as follows: bit 7 lock lost, bit 6 transmit PLL calibration failure, bit 5 receive PLL calibration failure, bit 4 RC oscillator calibration failure, bit 3 quick-start calibration failure, bit 2 EE checksum failure, bit 0 ADC conversion done.
- R3: A strobed read of address 0x01 returns the flags as they stand in that cycle. All flags are zero after the next clock edge.
- R4: An event pulse in the same cycle as a clearing read leaves its flag set, and the flag appears on the next read.
- R5: Bit 1 of the event register always equals the live `cmd_ready` input, and a read never clears it.
- R6: The busy register sits at address 0x02, with busy in bit 0 and bits 7:1 reading zero. Busy is high in any cycle where calibration, EE access, housekeeping or burst transmit activity is high.
- R7: Busy is high from the cycle of `rx_id_found` through the cycle of `rx_pkt_done`, and it falls in the cycle after the done pulse.
- R8: Busy is high from the cycle of `tx_buf_start` through the cycle of `tx_sent`, and it falls in the cycle after.
- R9: Reading address 0x02 or any unmapped address leaves the sticky flags unchanged. Unmapped addresses read as zero.
- R10: While `rd_en` is low, `rd_data` is zero.
- R11: A start pulse and a done pulse in the same cycle leave the span open, so busy stays high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_lock_lost | input | 1 | Pulse: PLL lost lock at startup |
| ev_txcal_fail | input | 1 | Pulse: transmit PLL calibration failed |
| ev_rxcal_fail | input | 1 | Pulse: receive PLL calibration failed |
| ev_rccal_fail | input | 1 | Pulse: RC oscillator calibration failed |
| ev_qscal_fail | input | 1 | Pulse: quick-start calibration failed |
| ev_csum_fail | input | 1 | Pulse: EE checksum failed |
| ev_adc_done | input | 1 | Pulse: ADC conversion complete |
| cmd_ready | input | 1 | Level: controller can accept a command |
| act_cal | input | 1 | Level: calibration sequence running |
| act_ee | input | 1 | Level: EE read or write running |
| act_hk | input | 1 | Level: housekeeping cycle running |
| act_burst | input | 1 | Level: burst transmission running |
| rx_id_found | input | 1 | Pulse: valid chip ID detected |
| rx_pkt_done | input | 1 | Pulse: received packet processing finished |
| tx_buf_start | input | 1 | Pulse: buffered transmit command accepted |
| tx_sent | input | 1 | Pulse: buffered packet fully sent |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Register address |
| rd_data | output | 8 | Read data, combinational |

## Verification
On every cycle, the assertions check the following: flags persist until cleared, a clearing read leaves only the events that coincide with it, the ready bit follows its input on reads, the busy register pads with zeros, and read data is zero without a strobe. The scenarios are needed to show full read sequences. These cover a flag seen once and then gone, a coincident event surviving to the next read, the bit placement of every event, and the exact first and last busy cycles of the receive and transmit spans, including the start-and-done collision.

// File: rtl/rss_pkg.sv
package rss_pkg;

    localparam int NUM_EVT = 7;
    localparam int REG_W   = 8;

    // flag vector index order (LSB first)
    typedef enum logic [2:0] {
        FI_ADC   = 3'd0,
        FI_CSUM  = 3'd1,
        FI_QS    = 3'd2,
        FI_RC    = 3'd3,
        FI_RXCAL = 3'd4,
        FI_TXCAL = 3'd5,
        FI_LOCK  = 3'd6
    } flag_idx_e;

    typedef struct packed {
        logic cal;
        logic ee;
        logic hk;
        logic burst;
        logic rx;
        logic tx;
    } busy_src_t;

    // event register: flags 6..1 go to bits 7..2, ready to bit 1, flag 0 to bit 0
    function automatic logic [REG_W-1:0] pack_evt_reg(input logic [NUM_EVT-1:0] f,
                                                     input logic ready);
        return {f[NUM_EVT-1:1], ready, f[0]};
    endfunction

    function automatic logic fold_busy(input busy_src_t s);
        return s.cal | s.ee | s.hk | s.burst | s.rx | s.tx;
    endfunction

    function automatic logic [REG_W-1:0] pack_busy_reg(input logic busy);
        return {{(REG_W-1){1'b0}}, busy};
    endfunction

endpackage

// File: rtl/rss_sticky_bit.sv
module rss_sticky_bit (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else
            q <= (q & ~clr) | set;   // new event beats clear
    end
endmodule

// File: rtl/rss_span_hold.sv
module rss_span_hold (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic done,
    output logic active
);
    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= 1'b0;
        else if (start)
            hold_q <= 1'b1;          // start wins over done
        else if (done)
            hold_q <= 1'b0;
    end

    assign active = hold_q | start;
endmodule

// File: rtl/rss_read_mux.sv
module rss_read_mux #(
    parameter int ADDR_W    = 4,
    parameter int EVT_ADDR  = 1,
    parameter int BUSY_ADDR = 2
) (
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [rss_pkg::REG_W-1:0]  evt_reg,
    input  logic [rss_pkg::REG_W-1:0]  busy_reg,
    output logic [rss_pkg::REG_W-1:0]  rd_data,
    output logic                       clr_flags
);
    localparam logic [ADDR_W-1:0] EVT_A  = ADDR_W'(EVT_ADDR);
    localparam logic [ADDR_W-1:0] BUSY_A = ADDR_W'(BUSY_ADDR);

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (rd_addr == EVT_A)
                rd_data = evt_reg;
            else if (rd_addr == BUSY_A)
                rd_data = busy_reg;
        end
    end

    assign clr_flags = rd_en && (rd_addr == EVT_A);
endmodule

// File: rtl/radio_status_unit.sv
module radio_status_unit #(
    parameter int ADDR_W    = 4,
    parameter int EVT_ADDR  = 1,
    parameter int BUSY_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_lock_lost,
    input  logic              ev_txcal_fail,
    input  logic              ev_rxcal_fail,
    input  logic              ev_rccal_fail,
    input  logic              ev_qscal_fail,
    input  logic              ev_csum_fail,
    input  logic              ev_adc_done,
    input  logic              cmd_ready,
    input  logic              act_cal,
    input  logic              act_ee,
    input  logic              act_hk,
    input  logic              act_burst,
    input  logic              rx_id_found,
    input  logic              rx_pkt_done,
    input  logic              tx_buf_start,
    input  logic              tx_sent,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    import rss_pkg::*;

    logic [NUM_EVT-1:0] ev_vec;
    logic [NUM_EVT-1:0] flag_q;
    logic               clr_flags;
    logic               rx_active;
    logic               tx_active;
    logic               busy_w;
    busy_src_t          bsrc;
    logic [REG_W-1:0]   evt_reg;
    logic [REG_W-1:0]   busy_reg;

    always_comb begin
        ev_vec           = '0;
        ev_vec[FI_ADC]   = ev_adc_done;
        ev_vec[FI_CSUM]  = ev_csum_fail;
        ev_vec[FI_QS]    = ev_qscal_fail;
        ev_vec[FI_RC]    = ev_rccal_fail;
        ev_vec[FI_RXCAL] = ev_rxcal_fail;
        ev_vec[FI_TXCAL] = ev_txcal_fail;
        ev_vec[FI_LOCK]  = ev_lock_lost;
    end

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
        rss_sticky_bit u_bit (
            .clk (clk),
            .rst (rst),
            .set (ev_vec[i]),
            .clr (clr_flags),
            .q   (flag_q[i])
        );
    end

    rss_span_hold u_rx_span (
        .clk    (clk),
        .rst    (rst),
        .start  (rx_id_found),
        .done   (rx_pkt_done),
        .active (rx_active)
    );

    rss_span_hold u_tx_span (
        .clk    (clk),
        .rst    (rst),
        .start  (tx_buf_start),
        .done   (tx_sent),
        .active (tx_active)
    );

    always_comb begin
        bsrc.cal   = act_cal;
        bsrc.ee    = act_ee;
        bsrc.hk    = act_hk;
        bsrc.burst = act_burst;
        bsrc.rx    = rx_active;
        bsrc.tx    = tx_active;
    end

    assign busy_w   = fold_busy(bsrc);
    assign evt_reg  = pack_evt_reg(flag_q, cmd_ready);
    assign busy_reg = pack_busy_reg(busy_w);

    rss_read_mux #(
        .ADDR_W    (ADDR_W),
        .EVT_ADDR  (EVT_ADDR),
        .BUSY_ADDR (BUSY_ADDR)
    ) u_rd (
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .evt_reg   (evt_reg),
        .busy_reg  (busy_reg),
        .rd_data   (rd_data),
        .clr_flags (clr_flags)
    );
endmodule

// File: rtl/rss_checker.sv
module rss_checker #(
    parameter int ADDR_W    = 4,
    parameter int EVT_ADDR  = 1,
    parameter int BUSY_ADDR = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [6:0]        ev_vec,
    input logic [6:0]        flag_q,
    input logic              cmd_ready,
    input logic              act_any,
    input logic              rx_id_found,
    input logic              rx_pkt_done,
    input logic              rx_active,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data
);
    logic rd_evt, rd_busy;
    assign rd_evt  = rd_en && (rd_addr == ADDR_W'(EVT_ADDR));
    assign rd_busy = rd_en && (rd_addr == ADDR_W'(BUSY_ADDR));

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        (ev_vec != 0) |=> ((flag_q & $past(ev_vec)) == $past(ev_vec)));

    p_keep_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_evt |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        rd_evt |=> (flag_q == $past(ev_vec)));

    p_no_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_evt) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    p_ready_r5: assert property (@(posedge clk) disable iff (rst)
        rd_evt |-> (rd_data[1] == cmd_ready));

    p_pad_r6: assert property (@(posedge clk) disable iff (rst)
        rd_busy |-> (rd_data[7:1] == 7'd0));

    p_level_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_busy && act_any) |-> rd_data[0]);

    p_rx_open_r7: assert property (@(posedge clk) disable iff (rst)
        rx_id_found |=> rx_active);

    p_rx_close_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_pkt_done && !rx_id_found) |=> !rx_active || rx_id_found);

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == 8'd0));
endmodule

bind radio_status_unit rss_checker #(
    .ADDR_W    (ADDR_W),
    .EVT_ADDR  (EVT_ADDR),
    .BUSY_ADDR (BUSY_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_vec      (ev_vec),
    .flag_q      (flag_q),
    .cmd_ready   (cmd_ready),
    .act_any     (act_cal | act_ee | act_hk | act_burst),
    .rx_id_found (rx_id_found),
    .rx_pkt_done (rx_pkt_done),
    .rx_active   (rx_active),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data)
);

// File: tb/radio_status_unit_test.sv
module radio_status_unit_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    // bench event vector: [6] lock [5] txcal [4] rxcal [3] rccal [2] qs [1] csum [0] adc
    logic [6:0] ev = '0;
    logic cmd_ready = 1'b1;
    logic act_cal = 0, act_ee = 0, act_hk = 0, act_burst = 0;
    logic rx_id_found = 0, rx_pkt_done = 0, tx_buf_start = 0, tx_sent = 0;
    logic rd_en = 0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    radio_status_unit uut (
        .clk(clk), .rst(rst),
        .ev_lock_lost(ev[6]), .ev_txcal_fail(ev[5]), .ev_rxcal_fail(ev[4]),
        .ev_rccal_fail(ev[3]), .ev_qscal_fail(ev[2]), .ev_csum_fail(ev[1]),
        .ev_adc_done(ev[0]), .cmd_ready(cmd_ready),
        .act_cal(act_cal), .act_ee(act_ee), .act_hk(act_hk), .act_burst(act_burst),
        .rx_id_found(rx_id_found), .rx_pkt_done(rx_pkt_done),
        .tx_buf_start(tx_buf_start), .tx_sent(tx_sent),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] exp_evt(input logic [6:0] f, input logic r);
        return {f[6:1], r, f[0]};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one-cycle strobed read; returns data sampled mid-cycle
    task automatic read_reg(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1; rd_addr = a;
        #2 d = rd_data;
        @(negedge clk);
        rd_en = 0; rd_addr = '0;
    endtask

    task automatic pulse_ev(input logic [6:0] v);
        @(negedge clk); ev = v;
        @(negedge clk); ev = '0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        #2 check("R10 idle", rd_data, 8'h00);
        read_reg(4'h1, d); check("R1 evt after reset", d, exp_evt(7'd0, 1'b1));
        read_reg(4'h2, d); check("R1 busy after reset", d, 8'h00);
    endtask

    task automatic t_each_flag;
        logic [7:0] d;
        for (int i = 0; i < 7; i++) begin
            pulse_ev(7'(1) << i);
            repeat (2) @(negedge clk);
            read_reg(4'h1, d); check("R2 flag placement", d, exp_evt(7'(1) << i, 1'b1));
            read_reg(4'h1, d); check("R3 cleared after read", d, exp_evt(7'd0, 1'b1));
        end
        pulse_ev(7'h55); pulse_ev(7'h2A);
        read_reg(4'h1, d); check("R2 accumulated flags", d, exp_evt(7'h7F, 1'b1));
        read_reg(4'h1, d); check("R3 all cleared", d, exp_evt(7'd0, 1'b1));
    endtask

    task automatic t_collide;
        logic [7:0] d;
        pulse_ev(7'h40);
        @(negedge clk);
        rd_en = 1; rd_addr = 4'h1; ev = 7'h01;
        #2 d = rd_data;
        check("R3 read shows prior flag", d, exp_evt(7'h40, 1'b1));
        @(negedge clk);
        rd_en = 0; ev = '0;
        read_reg(4'h1, d); check("R4 coincident event kept", d, exp_evt(7'h01, 1'b1));
    endtask

    task automatic t_ready;
        logic [7:0] d;
        cmd_ready = 0;
        read_reg(4'h1, d); check("R5 ready low", d, exp_evt(7'd0, 1'b0));
        cmd_ready = 1;
        read_reg(4'h1, d); check("R5 ready high", d, exp_evt(7'd0, 1'b1));
        read_reg(4'h1, d); check("R5 ready not cleared", d, exp_evt(7'd0, 1'b1));
    endtask

    task automatic t_levels;
        logic [7:0] d;
        act_cal = 1; read_reg(4'h2, d); check("R6 cal busy", d, 8'h01); act_cal = 0;
        act_ee = 1; read_reg(4'h2, d); check("R6 ee busy", d, 8'h01); act_ee = 0;
        act_hk = 1; read_reg(4'h2, d); check("R6 hk busy", d, 8'h01); act_hk = 0;
        act_burst = 1; read_reg(4'h2, d); check("R6 burst busy", d, 8'h01); act_burst = 0;
        read_reg(4'h2, d); check("R6 idle", d, 8'h00);
    endtask

    task automatic t_rx_span;
        @(negedge clk); rd_en = 1; rd_addr = 4'h2;
        #2 check("R7 before id", rd_data, 8'h00);
        @(negedge clk); rx_id_found = 1;
        #2 check("R7 id cycle", rd_data, 8'h01);
        @(negedge clk); rx_id_found = 0;
        repeat (3) @(negedge clk);
        #2 check("R7 processing", rd_data, 8'h01);
        @(negedge clk); rx_pkt_done = 1;
        #2 check("R7 done cycle", rd_data, 8'h01);
        @(negedge clk); rx_pkt_done = 0;
        #2 check("R7 after done", rd_data, 8'h00);
        @(negedge clk); rd_en = 0;
    endtask

    task automatic t_tx_span;
        @(negedge clk); rd_en = 1; rd_addr = 4'h2; tx_buf_start = 1;
        #2 check("R8 start cycle", rd_data, 8'h01);
        @(negedge clk); tx_buf_start = 0;
        repeat (4) @(negedge clk);
        #2 check("R8 sending", rd_data, 8'h01);
        @(negedge clk); tx_sent = 1;
        #2 check("R8 sent cycle", rd_data, 8'h01);
        @(negedge clk); tx_sent = 0;
        #2 check("R8 after sent", rd_data, 8'h00);
        @(negedge clk); rd_en = 0;
    endtask

    task automatic t_collision_span;
        @(negedge clk); rd_en = 1; rd_addr = 4'h2;
        rx_id_found = 1; rx_pkt_done = 1;
        @(negedge clk); rx_id_found = 0; rx_pkt_done = 0;
        #2 check("R11 rx span open", rd_data, 8'h01);
        @(negedge clk); rx_pkt_done = 1;
        @(negedge clk); rx_pkt_done = 0;
        #2 check("R11 rx span closed", rd_data, 8'h00);
        @(negedge clk); tx_buf_start = 1; tx_sent = 1;
        @(negedge clk); tx_buf_start = 0; tx_sent = 0;
        #2 check("R11 tx span open", rd_data, 8'h01);
        @(negedge clk); tx_sent = 1;
        @(negedge clk); tx_sent = 0;
        #2 check("R11 tx span closed", rd_data, 8'h00);
        @(negedge clk); rd_en = 0;
    endtask

    task automatic t_other_reads;
        logic [7:0] d;
        pulse_ev(7'h12);
        read_reg(4'h2, d); check("R9 busy read", d, 8'h00);
        read_reg(4'h7, d); check("R9 unmapped reads zero", d, 8'h00);
        read_reg(4'h0, d); check("R9 addr0 zero", d, 8'h00);
        @(negedge clk); #2 check("R10 no strobe", rd_data, 8'h00);
        read_reg(4'h1, d); check("R9 flags survived", d, exp_evt(7'h12, 1'b1));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_each_flag();
        t_collide();
        t_ready();
        t_levels();
        t_rx_span();
        t_tx_span();
        t_collision_span();
        t_other_reads();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule